// File: doc/BRIEF.md
# Control-Flow Trace Buffer Controller

This block records control-flow change records into a 256-entry on-chip store so that a debugger can later rebuild the path a program took. Each recorded event carries an 8-bit entry byte and a 32-bit branch target. Two capture policies exist. In fill-once mode recording stops when the store is full, and a one-cycle debug-exception pulse is raised. In wrap-around mode new records overwrite the oldest ones until tracing is switched off.

Software drains the store through a small coprocessor-style register port. One register returns trace entries oldest first. Two checkpoint registers hold target addresses of marked events, which anchor the history once the store has wrapped. Register access is allowed only in privileged mode. An access from user mode, or a data-processing operation aimed at the port, raises an undefined-access pulse and changes nothing else.

Top module: `trace_buf_ctrl`

## Requirements
- R1: After reset, dbg_exc_o, undef_o and reg_rdata_o are 0, and a read of the trace register returns 0.
- R2: A privileged read (reg_we_i=0, reg_dp_i=0, reg_aux_i=0) with reg_sel_i=11 returns the oldest remaining entry, zero-extended into bits 7:0, in reg_rdata_o on the cycle after the request, and removes that entry. reg_rdata_o is 0 on every cycle that does not follow a read request.
- R3: In fill-once mode (trc_wrap_i=0), recording the 256th entry raises dbg_exc_o for exactly one cycle, on the cycle after that record. Later events are ignored until tracing is re-enabled, and all 256 entries read back in order.
- R4: In wrap-around mode (trc_wrap_i=1), events beyond 256 overwrite the oldest entries. Readout then returns the latest 256 entries, oldest first, and dbg_exc_o stays 0.
- R5: A read of the trace register while it is empty returns 0 and changes no state.
- R6: An event is not recorded while trc_en_i is 0, or in any cycle in which reg_req_i is 1.
- R7: A rising edge of trc_en_i empties the store. No event is recorded in that cycle.
- R8: A recorded event with evt_ckpt_i=1 loads its target into checkpoint 0 or checkpoint 1. The two alternate, starting with checkpoint 0 after reset and after each rising edge of trc_en_i.
- R9: Selector 12 (checkpoint 0) and selector 13 (checkpoint 1) are 32-bit read/write registers for privileged software.
- R10: An access with user_mode_i=1 pulses undef_o on the next cycle, returns 0, does not write a checkpoint, and does not consume a trace entry.
- R11: An access with reg_dp_i=1 pulses undef_o on the next cycle and has no other effect.
- R12: A privileged access with a nonzero reg_aux_i, or with a selector other than 11 to 13, has no effect, returns 0, and does not raise undef_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trc_en_i | input | 1 | Tracing enable; a rising edge clears the store |
| trc_wrap_i | input | 1 | Capture policy: 0 fill-once, 1 wrap-around |
| evt_valid_i | input | 1 | Control-flow event strobe |
| evt_data_i | input | 8 | Entry byte of the event |
| evt_target_i | input | 32 | Branch target address of the event |
| evt_ckpt_i | input | 1 | Event is checkpoint-worthy |
| user_mode_i | input | 1 | Processor is in user (unprivileged) mode |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 write, 0 read |
| reg_dp_i | input | 1 | Access is a data-processing (non-transfer) operation |
| reg_sel_i | input | 4 | Register number: 11 trace, 12 checkpoint 0, 13 checkpoint 1 |
| reg_aux_i | input | 10 | Remaining selector fields; must be zero |
| reg_wdata_i | input | 32 | Write data |
| dbg_exc_o | output | 1 | Debug-exception pulse when the fill-once capture completes |
| undef_o | output | 1 | Undefined-access pulse |
| reg_rdata_o | output | 32 | Read data, valid on the cycle after a read request |

## Verification
The trace store is filled with a counting byte pattern in fill-once mode. This shows whether the stop point and the exception cycle are correct, and whether the store drops or duplicates entries at the 256 boundary. A stream of 300 events with a stride-3 pattern in wrap-around mode shows whether overwrite and the readout start point follow the oldest surviving entry, not index zero. Single events presented while tracing is disabled, or in the same cycle as a register access, show whether suppression works. Marked events with distinct targets, and user-mode, data-processing and nonzero-field accesses placed between privileged reads, show alternation order and side-effect-free rejection.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    localparam int unsigned SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_TRACE = 4'd11;
    localparam logic [SEL_W-1:0] SEL_CK0   = 4'd12;
    localparam logic [SEL_W-1:0] SEL_CK1   = 4'd13;

    typedef enum logic {
        MODE_FILL = 1'b0,
        MODE_WRAP = 1'b1
    } tbc_mode_e;
endpackage

// File: rtl/tbc_store.sv
module tbc_store #(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned ENTRY_W = 8,
    localparam int unsigned PW     = $clog2(DEPTH)
) (
    input  logic               clk_i,
    input  logic               wr_i,
    input  logic [PW-1:0]      waddr_i,
    input  logic [ENTRY_W-1:0] wdata_i,
    input  logic [PW-1:0]      raddr_i,
    output logic [ENTRY_W-1:0] rdata_o
);
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
    import tbc_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  tbc_mode_e     mode_i,
    input  logic          evt_i,
    input  logic          busy_i,
    input  logic          pop_i,
    output logic          wr_o,
    output logic          start_o,
    output logic [PW-1:0] wptr_o,
    output logic [PW-1:0] rptr_o,
    output logic          empty_o,
    output logic          exc_o
);
    typedef struct packed {
        logic          en;
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          stop;
        logic          exc;
    } ctrl_t;

    ctrl_t q, d;
    logic  start, full, rec;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d     = q;
        d.en  = en_i;
        d.exc = 1'b0;
        start = en_i && !q.en;
        full  = (q.cnt == CW'(DEPTH));
        rec   = en_i && !start && evt_i && !busy_i && !q.stop
                && !(full && mode_i == MODE_FILL);
        if (start) begin
            d.wptr = '0;
            d.rptr = '0;
            d.cnt  = '0;
            d.stop = 1'b0;
        end else begin
            if (rec) begin
                d.wptr = adv(q.wptr);
                if (full) begin
                    d.rptr = adv(q.rptr);
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
                if (mode_i == MODE_FILL && q.cnt == CW'(DEPTH - 1)) begin
                    d.stop = 1'b1;
                    d.exc  = 1'b1;
                end
            end
            if (pop_i && q.cnt != '0) begin
                d.rptr = adv(q.rptr);
                d.cnt  = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_o    = rec;
    assign start_o = start;
    assign wptr_o  = q.wptr;
    assign rptr_o  = q.rptr;
    assign empty_o = (q.cnt == '0);
    assign exc_o   = q.exc;

    p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= CW'(DEPTH));
    p_exc_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_o |=> !exc_o);
    p_no_write_after_exc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_o && q.en) |-> !wr_o);
    p_idle_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i || busy_i) |-> !wr_o);
    p_start_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> empty_o);
endmodule

// File: rtl/tbc_regs.sv
module tbc_regs
    import tbc_pkg::*;
#(
    parameter int unsigned ENTRY_W = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned AUX_W   = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               we_i,
    input  logic               dp_i,
    input  logic               user_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [AUX_W-1:0]   aux_i,
    input  logic [ADDR_W-1:0]  wdata_i,
    input  logic               rec_i,
    input  logic               ckpt_i,
    input  logic [ADDR_W-1:0]  tgt_i,
    input  logic               start_i,
    input  logic               empty_i,
    input  logic [ENTRY_W-1:0] entry_i,
    output logic               pop_o,
    output logic               undef_o,
    output logic [ADDR_W-1:0]  rdata_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] ck0;
        logic [ADDR_W-1:0] ck1;
        logic              ck_sel;
        logic [ADDR_W-1:0] rdata;
        logic              undef;
    } regs_t;

    regs_t q, d;
    logic  ok;

    always_comb begin
        d       = q;
        ok      = req_i && !user_i && !dp_i && (aux_i == '0);
        d.undef = req_i && (user_i || dp_i);
        d.rdata = '0;
        pop_o   = ok && !we_i && (sel_i == SEL_TRACE) && !empty_i;
        if (ok && !we_i) begin
            unique case (sel_i)
                SEL_TRACE: d.rdata = empty_i ? '0 : ADDR_W'(entry_i);
                SEL_CK0:   d.rdata = q.ck0;
                SEL_CK1:   d.rdata = q.ck1;
                default:   d.rdata = '0;
            endcase
        end
        if (ok && we_i) begin
            if (sel_i == SEL_CK0) d.ck0 = wdata_i;
            if (sel_i == SEL_CK1) d.ck1 = wdata_i;
        end
        if (start_i) begin
            d.ck_sel = 1'b0;
        end else if (rec_i && ckpt_i) begin
            if (q.ck_sel) d.ck1 = tgt_i;
            else          d.ck0 = tgt_i;
            d.ck_sel = !q.ck_sel;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign undef_o = q.undef;
    assign rdata_o = q.rdata;

    p_user_undef_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && user_i) |=> (undef_o && rdata_o == '0));
    p_user_no_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && user_i) |-> !pop_o);
    p_dp_undef_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && dp_i) |=> undef_o);
    p_idle_rdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_i && !we_i) |=> (rdata_o == '0));
    p_aux_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !user_i && !dp_i && aux_i != '0) |=> (!undef_o && rdata_o == '0));
    p_empty_no_pop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_i |-> !pop_o);
endmodule

// File: rtl/trace_buf_ctrl.sv
module trace_buf_ctrl
    import tbc_pkg::*;
#(
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned ENTRY_W = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned AUX_W   = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trc_en_i,
    input  logic               trc_wrap_i,
    input  logic               evt_valid_i,
    input  logic [ENTRY_W-1:0] evt_data_i,
    input  logic [ADDR_W-1:0]  evt_target_i,
    input  logic               evt_ckpt_i,
    input  logic               user_mode_i,
    input  logic               reg_req_i,
    input  logic               reg_we_i,
    input  logic               reg_dp_i,
    input  logic [SEL_W-1:0]   reg_sel_i,
    input  logic [AUX_W-1:0]   reg_aux_i,
    input  logic [ADDR_W-1:0]  reg_wdata_i,
    output logic               dbg_exc_o,
    output logic               undef_o,
    output logic [ADDR_W-1:0]  reg_rdata_o
);
    localparam int unsigned PW = $clog2(DEPTH);

    logic               wr, start, empty, pop;
    logic [PW-1:0]      wptr, rptr;
    logic [ENTRY_W-1:0] entry;

    tbc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (trc_en_i),
        .mode_i  (tbc_mode_e'(trc_wrap_i)),
        .evt_i   (evt_valid_i),
        .busy_i  (reg_req_i),
        .pop_i   (pop),
        .wr_o    (wr),
        .start_o (start),
        .wptr_o  (wptr),
        .rptr_o  (rptr),
        .empty_o (empty),
        .exc_o   (dbg_exc_o)
    );

    tbc_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk_i   (clk_i),
        .wr_i    (wr),
        .waddr_i (wptr),
        .wdata_i (evt_data_i),
        .raddr_i (rptr),
        .rdata_o (entry)
    );

    tbc_regs #(.ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .AUX_W(AUX_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (reg_req_i),
        .we_i    (reg_we_i),
        .dp_i    (reg_dp_i),
        .user_i  (user_mode_i),
        .sel_i   (reg_sel_i),
        .aux_i   (reg_aux_i),
        .wdata_i (reg_wdata_i),
        .rec_i   (wr),
        .ckpt_i  (evt_ckpt_i),
        .tgt_i   (evt_target_i),
        .start_i (start),
        .empty_i (empty),
        .entry_i (entry),
        .pop_o   (pop),
        .undef_o (undef_o),
        .rdata_o (reg_rdata_o)
    );
endmodule

// File: tb/trace_buf_ctrl_test.sv
`timescale 1ns/1ps
module trace_buf_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        trc_en_i = 1'b0, trc_wrap_i = 1'b0;
    logic        evt_valid_i = 1'b0, evt_ckpt_i = 1'b0;
    logic [7:0]  evt_data_i = '0;
    logic [31:0] evt_target_i = '0;
    logic        user_mode_i = 1'b0, reg_req_i = 1'b0, reg_we_i = 1'b0, reg_dp_i = 1'b0;
    logic [3:0]  reg_sel_i = '0;
    logic [9:0]  reg_aux_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        dbg_exc_o, undef_o;
    logic [31:0] reg_rdata_o;

    int tests = 0, fails = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        logic        undef;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    trace_buf_ctrl uut (.*, .clk_i(clk));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic evt(logic [7:0] b, logic [31:0] t, logic ck);
        evt_valid_i = 1'b1; evt_data_i = b; evt_target_i = t; evt_ckpt_i = ck;
        @(negedge clk);
        evt_valid_i = 1'b0; evt_ckpt_i = 1'b0;
    endtask

    task automatic acc(logic we, logic dp, logic usr, logic [3:0] sel, logic [9:0] aux,
                       logic [31:0] wd, logic [31:0] exp_d, logic exp_u, string tag,
                       logic with_evt = 1'b0);
        item_t it;
        it.data = exp_d; it.undef = exp_u; it.tag = tag;
        sb.push_back(it);
        reg_req_i = 1'b1; reg_we_i = we; reg_dp_i = dp; user_mode_i = usr;
        reg_sel_i = sel; reg_aux_i = aux; reg_wdata_i = wd;
        evt_valid_i = with_evt; evt_data_i = 8'h5A;
        @(negedge clk);
        reg_req_i = 1'b0; reg_we_i = 1'b0; reg_dp_i = 1'b0; user_mode_i = 1'b0;
        evt_valid_i = 1'b0;
    endtask

    task automatic rd(logic [3:0] sel, logic [31:0] exp_d, string tag);
        acc(1'b0, 1'b0, 1'b0, sel, '0, '0, exp_d, 1'b0, tag);
    endtask

    task automatic restart(logic wrap);
        trc_en_i = 1'b0;
        @(negedge clk);
        trc_en_i = 1'b1; trc_wrap_i = wrap;
        @(negedge clk);
    endtask

    // monitor: compares each register response with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (reg_req_i) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    chk("scoreboard underrun", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk({it.tag, " rdata"}, reg_rdata_o, it.data);
                    chk({it.tag, " undef"}, {31'd0, undef_o}, {31'd0, it.undef});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 exc", {31'd0, dbg_exc_o}, 32'd0);
        chk("R1 undef", {31'd0, undef_o}, 32'd0);
        chk("R1 rdata", reg_rdata_o, 32'd0);
        rd(4'd11, 32'd0, "R1 empty trace read");

        // R3 fill-once
        restart(1'b0);
        for (int i = 0; i < 256; i++) begin
            evt(i[7:0], 32'h1000 + i, 1'b0);
            if (i == 254) chk("R3 no early exc", {31'd0, dbg_exc_o}, 32'd0);
        end
        chk("R3 exc pulse", {31'd0, dbg_exc_o}, 32'd1);
        evt(8'hEE, 32'h0, 1'b0);
        chk("R3 exc one cycle", {31'd0, dbg_exc_o}, 32'd0);
        for (int i = 0; i < 256; i++) rd(4'd11, {24'd0, i[7:0]}, "R3/R2 fill readout");
        rd(4'd11, 32'd0, "R5 read past empty");
        rd(4'd11, 32'd0, "R5 second empty read");

        // R4 wrap-around
        restart(1'b1);
        for (int i = 0; i < 300; i++) begin
            evt(8'((i * 3 + 1) & 8'hFF), 32'h0, 1'b0);
            if (dbg_exc_o) chk("R4 no exc in wrap", 32'd1, 32'd0);
        end
        for (int i = 44; i < 300; i++) rd(4'd11, 32'((i * 3 + 1) & 8'hFF), "R4 wrap readout");
        rd(4'd11, 32'd0, "R4 empty after wrap readout");

        // R6 disabled / busy suppression
        trc_en_i = 1'b0;
        evt(8'h77, 32'h0, 1'b0);
        rd(4'd11, 32'd0, "R6 disabled event ignored");
        trc_en_i = 1'b1;
        @(negedge clk);
        acc(1'b0, 1'b0, 1'b0, 4'd12, '0, '0, 32'd0, 1'b0, "R6 ckpt read with event", 1'b1);
        rd(4'd11, 32'd0, "R6 event during access ignored");

        // R7 re-enable clears
        evt(8'h33, 32'h0, 1'b0);
        restart(1'b1);
        rd(4'd11, 32'd0, "R7 cleared by enable rise");
        evt(8'h44, 32'h0, 1'b0);
        rd(4'd11, 32'h44, "R7 capture after enable rise");

        // R8 checkpoint alternation
        restart(1'b1);
        evt(8'h01, 32'hA000_0001, 1'b1);
        evt(8'h02, 32'hB000_0002, 1'b0);
        evt(8'h03, 32'hC000_0003, 1'b1);
        rd(4'd12, 32'hA000_0001, "R8 first mark to ck0");
        rd(4'd13, 32'hC000_0003, "R8 second mark to ck1");
        evt(8'h04, 32'hD000_0004, 1'b1);
        rd(4'd12, 32'hD000_0004, "R8 third mark back to ck0");
        rd(4'd13, 32'hC000_0003, "R8 ck1 kept");

        // R9 software access
        acc(1'b1, 1'b0, 1'b0, 4'd12, '0, 32'hDEAD_BEEF, 32'd0, 1'b0, "R9 write ck0");
        acc(1'b1, 1'b0, 1'b0, 4'd13, '0, 32'h1234_5678, 32'd0, 1'b0, "R9 write ck1");
        rd(4'd12, 32'hDEAD_BEEF, "R9 read ck0");
        rd(4'd13, 32'h1234_5678, "R9 read ck1");

        // R10 user mode
        acc(1'b1, 1'b0, 1'b1, 4'd12, '0, 32'h0BAD_0BAD, 32'd0, 1'b1, "R10 user write");
        rd(4'd12, 32'hDEAD_BEEF, "R10 ck0 unchanged");
        acc(1'b0, 1'b0, 1'b1, 4'd11, '0, '0, 32'd0, 1'b1, "R10 user trace read");
        rd(4'd11, 32'h01, "R10 entry not consumed");

        // R11 data-processing op
        acc(1'b1, 1'b1, 1'b0, 4'd13, '0, 32'hFFFF_0000, 32'd0, 1'b1, "R11 dp op");
        rd(4'd13, 32'h1234_5678, "R11 ck1 unchanged");

        // R12 nonzero aux / unknown selector
        acc(1'b0, 1'b0, 1'b0, 4'd12, 10'h004, '0, 32'd0, 1'b0, "R12 aux read");
        acc(1'b1, 1'b0, 1'b0, 4'd12, 10'h100, 32'h5555_5555, 32'd0, 1'b0, "R12 aux write");
        rd(4'd5, 32'd0, "R12 unknown selector");
        acc(1'b0, 1'b0, 1'b0, 4'd11, 10'h001, '0, 32'd0, 1'b0, "R12 aux trace read");
        rd(4'd12, 32'hDEAD_BEEF, "R12 ck0 unchanged");
        rd(4'd11, 32'h02, "R12 entry not consumed");

        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", sb.size(), 32'd0);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule